// File: doc/BRIEF.md
# Mailbox Channel Queue

This block is one direction of a message path between two processors. The sending side presents a 32-bit word together with a push strobe. The receiving side raises a pop strobe and finds the oldest stored word on the read-data output one clock later. The words are held first-in first-out in a store of parameterised depth. The depth may be 1 to 255, and 4, 8 and 16 are the usual sizes.

The queue reports an empty flag, a full flag and an 8-bit count of stored words. It also keeps two interrupt sources: "has data" (bit 0) and "has room" (bit 1). Each source has a mask bit and a pending bit. A pending bit latches only while its mask bit is on. Software clears a pending bit by writing a one to it. The channel interrupt is raised when a pending bit is set and its mask bit is on. Bus decoding and the merging of interrupts from several channels are done outside this block.

Top module: `mbox_channel`

## Requirements
- R1: An accepted push appends `pushData` to the queue. A pop of a non-empty queue moves the oldest word onto `popData` at the clock edge that takes the pop, so words leave in the order they entered.
- R2: `occupancy` is the number of stored words. It rises by one for each accepted push, falls by one for each accepted pop, and never exceeds DEPTH.
- R3: `isEmpty` is 1 exactly when `occupancy` is 0, and `isFull` is 1 exactly when `occupancy` equals DEPTH. Reset gives occupancy 0, isEmpty 1, isFull 0, popData 0, all pending bits 0 and all mask bits 0.
- R4: A push while the queue is full is dropped. The count does not change and the stored words are unchanged.
- R5: A pop while the queue is empty changes no state. `popData` keeps the last value it held.
- R6: A push and a pop in the same cycle, on a queue that is neither empty nor full, leave `occupancy` unchanged and keep the word order.
- R7: Pending bit 0 (has data) sets at the edge that follows a cycle in which the queue was non-empty and mask bit 0 was 1. Pending bit 1 (has room) sets at the edge that follows a cycle in which the queue was not full and mask bit 1 was 1.
- R8: A pending bit never sets while its mask bit is 0.
- R9: A one in `pendClr` clears that pending bit, and a zero leaves it alone. If a clear and a set condition meet in the same cycle, the set wins.
- R10: `maskWrEn` loads `maskWrData` into the mask at the next edge. `irq` is 1 exactly when some pending bit has its mask bit set. Turning a mask bit off lowers `irq` for that source without clearing its pending bit.
- R11: A push and a pop together on a full queue take the pop and drop the push. A push and a pop together on an empty queue take the push and ignore the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushReq | input | 1 | Push strobe |
| pushData | input | 32 | Word to push |
| popReq | input | 1 | Pop strobe |
| popData | output | 32 | Last word popped |
| isEmpty | output | 1 | Queue empty |
| isFull | output | 1 | Queue full |
| occupancy | output | 8 | Stored word count |
| maskWrEn | input | 1 | Mask load strobe |
| maskWrData | input | 2 | New mask value (bit 0 has data, bit 1 has room) |
| pendClr | input | 2 | Write-one-to-clear strobes for the pending bits |
| irqPending | output | 2 | Pending bits |
| irqMask | output | 2 | Mask bits |
| irq | output | 1 | Channel interrupt request |

## Verification
The bench builds the channel with DEPTH set to 4, the small preset. With that depth, a handful of pushes fills the queue, so the cases that occur only when full come within easy reach: dropped pushes, a push and pop together at full, and the has-room source going quiet. The same short runs also drain the queue, which brings in the empty-side cases: stale reads and a push and pop together at empty. The default depth of 8 is covered only by elaborating the design, since the logic that depends on depth is the same at any size.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MSG_W     = 32;
  localparam int OCC_W     = 8;
  localparam int PTR_MAX_W = 8;
  localparam int SRC_N     = 2;

  // interrupt source positions
  localparam int SRC_HAS_DATA = 0;
  localparam int SRC_HAS_ROOM = 1;

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic [PTR_MAX_W-1:0] wrPtr;
    logic [PTR_MAX_W-1:0] rdPtr;
  } fifoStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  output fifoStrobes_t     strobes,
  output logic [OCC_W-1:0] occupancy,
  output logic             isEmpty,
  output logic             isFull
);
  localparam logic [OCC_W-1:0]     DEPTH_C = OCC_W'(DEPTH);
  localparam logic [PTR_MAX_W-1:0] LAST_C  = PTR_MAX_W'(DEPTH - 1);

  logic                 wrEn, rdEn;
  logic [PTR_MAX_W-1:0] wrPtr, rdPtr, wrPtrNext, rdPtrNext;
  logic [OCC_W-1:0]     count, countNext;
  logic                 emptyQ, fullQ;

  assign wrEn = pushReq && !fullQ;
  assign rdEn = popReq && !emptyQ;

  always_comb begin
    unique case ({wrEn, rdEn})
      2'b10:   countNext = count + 1'b1;
      2'b01:   countNext = count - 1'b1;
      default: countNext = count;
    endcase
  end

  generate
    if (DEPTH == 1) begin : g_single
      assign wrPtrNext = '0;
      assign rdPtrNext = '0;
    end else begin : g_wrap
      always_comb begin
        wrPtrNext = wrPtr;
        rdPtrNext = rdPtr;
        if (wrEn) wrPtrNext = (wrPtr == LAST_C) ? '0 : wrPtr + 1'b1;
        if (rdEn) rdPtrNext = (rdPtr == LAST_C) ? '0 : rdPtr + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      wrPtr  <= '0;
      rdPtr  <= '0;
      emptyQ <= 1'b1;
      fullQ  <= 1'b0;
    end else begin
      count  <= countNext;
      wrPtr  <= wrPtrNext;
      rdPtr  <= rdPtrNext;
      emptyQ <= (countNext == '0);
      fullQ  <= (countNext == DEPTH_C);
    end
  end

  always_comb begin
    strobes.wrEn  = wrEn;
    strobes.rdEn  = rdEn;
    strobes.wrPtr = wrPtr;
    strobes.rdPtr = rdPtr;
  end

  assign occupancy = count;
  assign isEmpty   = emptyQ;
  assign isFull    = fullQ;
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic [MSG_W-1:0] pushData,
  output logic [MSG_W-1:0] popData
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [MSG_W-1:0] store [DEPTH];
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [MSG_W-1:0] headWord;

  assign wrIdx    = strobes.wrPtr[IDX_W-1:0];
  assign rdIdx    = strobes.rdPtr[IDX_W-1:0];
  assign headWord = store[rdIdx];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrIdx] <= pushData;
  end

  // read register keeps the last popped word when no pop is taken
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             popData <= '0;
    else if (strobes.rdEn) popData <= headWord;
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             isEmpty,
  input  logic             isFull,
  input  logic             maskWrEn,
  input  logic [SRC_N-1:0] maskWrData,
  input  logic [SRC_N-1:0] pendClr,
  output logic [SRC_N-1:0] pending,
  output logic [SRC_N-1:0] mask,
  output logic             irq
);
  logic [SRC_N-1:0] cond, pendNext;

  always_comb begin
    cond               = '0;
    cond[SRC_HAS_DATA] = !isEmpty;
    cond[SRC_HAS_ROOM] = !isFull;
  end

  // set term applied after the clear, so a live condition wins
  assign pendNext = (pending & ~pendClr) | (cond & mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      mask    <= '0;
    end else begin
      pending <= pendNext;
      if (maskWrEn) mask <= maskWrData;
    end
  end

  assign irq = |(pending & mask);
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushReq,
  input  logic [31:0] pushData,
  input  logic        popReq,
  output logic [31:0] popData,
  output logic        isEmpty,
  output logic        isFull,
  output logic [7:0]  occupancy,
  input  logic        maskWrEn,
  input  logic [1:0]  maskWrData,
  input  logic [1:0]  pendClr,
  output logic [1:0]  irqPending,
  output logic [1:0]  irqMask,
  output logic        irq
);
  fifoStrobes_t strobes;

  mbox_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pushReq   (pushReq),
    .popReq    (popReq),
    .strobes   (strobes),
    .occupancy (occupancy),
    .isEmpty   (isEmpty),
    .isFull    (isFull)
  );

  mbox_datapath #(.DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pushData (pushData),
    .popData  (popData)
  );

  mbox_irq u_irq (
    .clk        (clk),
    .rstN       (rstN),
    .isEmpty    (isEmpty),
    .isFull     (isFull),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .pendClr    (pendClr),
    .pending    (irqPending),
    .mask       (irqMask),
    .irq        (irq)
  );
endmodule

// File: rtl/mbox_channel_chk.sv
module mbox_channel_chk #(
  parameter int DEPTH = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        pushReq,
  input logic        popReq,
  input logic [31:0] popData,
  input logic        isEmpty,
  input logic        isFull,
  input logic [7:0]  occupancy,
  input logic [1:0]  pendClr,
  input logic [1:0]  irqPending,
  input logic [1:0]  irqMask,
  input logic        irq
);
  localparam logic [7:0] DEPTH_C = 8'(DEPTH);

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= DEPTH_C);

  assert_empty_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty == (occupancy == 8'd0));

  assert_full_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    isFull == (occupancy == DEPTH_C));

  assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && isFull) |=> ($stable(occupancy) && isFull));

  assert_stale_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && isEmpty) |=> ($stable(popData) && isEmpty));

  assert_both_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq && !isEmpty && !isFull) |=> $stable(occupancy));

  assert_data_set_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending[0]) |-> $past(irqMask[0]));

  assert_room_set_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending[1]) |-> $past(irqMask[1]));

  assert_clear_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr[0] && !(irqMask[0] && !isEmpty)) |=> !irqPending[0]);

  assert_clear_room_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr[1] && !(irqMask[1] && !isFull)) |=> !irqPending[1]);

  assert_quiet_unmasked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqMask == 2'b00) |-> !irq);
endmodule

bind mbox_channel mbox_channel_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pushReq    (pushReq),
  .popReq     (popReq),
  .popData    (popData),
  .isEmpty    (isEmpty),
  .isFull     (isFull),
  .occupancy  (occupancy),
  .pendClr    (pendClr),
  .irqPending (irqPending),
  .irqMask    (irqMask),
  .irq        (irq)
);

// File: tb/mbox_channel_tb.sv
`timescale 1ns/1ps
module mbox_channel_tb;
  localparam int DEPTH = 4;
  localparam int WATCHDOG_NS = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushReq = 1'b0, popReq = 1'b0, maskWrEn = 1'b0;
  logic [31:0] pushData = '0;
  logic [1:0]  maskWrData = '0, pendClr = '0;
  logic [31:0] popData;
  logic        isEmpty, isFull, irq;
  logic [7:0]  occupancy;
  logic [1:0]  irqPending, irqMask;

  int total = 0;
  int failed = 0;

  // reference state
  logic [31:0] expQ[$];
  logic [31:0] mLast = '0;
  logic [1:0]  mPend = '0, mMask = '0;

  always #2 clk = ~clk;

  mbox_channel #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .pushData(pushData),
    .popReq(popReq), .popData(popData), .isEmpty(isEmpty), .isFull(isFull),
    .occupancy(occupancy), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .pendClr(pendClr), .irqPending(irqPending), .irqMask(irqMask), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    int n = expQ.size();
    chk(tag, "occupancy", 32'(occupancy), 32'(n));
    chk(tag, "isEmpty", 32'(isEmpty), 32'(n == 0));
    chk(tag, "isFull", 32'(isFull), 32'(n == DEPTH));
    chk(tag, "popData", popData, mLast);
    chk(tag, "irqPending", 32'(irqPending), 32'(mPend));
    chk(tag, "irqMask", 32'(irqMask), 32'(mMask));
    chk(tag, "irq", 32'(irq), 32'(|(mPend & mMask)));
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input string tag, input logic push, input logic [31:0] d,
                      input logic pop, input logic [1:0] clr,
                      input logic mw, input logic [1:0] md);
    int   n = expQ.size();
    logic [1:0] cond;
    pushReq = push; pushData = d; popReq = pop;
    pendClr = clr; maskWrEn = mw; maskWrData = md;
    cond  = {logic'(n != DEPTH), logic'(n != 0)};
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0; pendClr = '0; maskWrEn = 1'b0;
    mPend = (mPend & ~clr) | (cond & mMask);
    if (mw) mMask = md;
    if (pop && n > 0) mLast = expQ.pop_front();
    if (push && n < DEPTH) expQ.push_back(d);
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, '0, 1'b0, 2'b00, 1'b0, 2'b00);
  endtask
  task automatic push(input string tag, input logic [31:0] d);
    step(tag, 1'b1, d, 1'b0, 2'b00, 1'b0, 2'b00);
  endtask
  task automatic pop(input string tag);
    step(tag, 1'b0, '0, 1'b1, 2'b00, 1'b0, 2'b00);
  endtask

  initial begin
    #WATCHDOG_NS;
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R3 reset");

    pop("R5 pop empty");
    push("R1 push a", 32'hA000_0001);
    push("R2 push b", 32'hB000_0002);
    push("R2 push c", 32'hC000_0003);
    pop("R1 pop a");
    pop("R1 pop b");
    step("R6 push+pop mid", 1'b1, 32'hD000_0004, 1'b1, 2'b00, 1'b0, 2'b00);
    pop("R6 order c");
    pop("R6 order d");
    pop("R5 stale after drain");
    idle("R5 hold");

    for (int i = 0; i < DEPTH; i++) push("R3 fill", 32'h1000_0000 + 32'(i));
    push("R4 drop when full", 32'hDEAD_BEEF);
    step("R11 push+pop at full", 1'b1, 32'hBAD0_0001, 1'b1, 2'b00, 1'b0, 2'b00);
    for (int i = 0; i < DEPTH; i++) pop("R4 contents intact");
    step("R11 push+pop at empty", 1'b1, 32'h5555_AAAA, 1'b1, 2'b00, 1'b0, 2'b00);

    idle("R8 no set while masked");
    step("R10 load mask data", 1'b0, '0, 1'b0, 2'b00, 1'b1, 2'b01);
    idle("R7 has-data pending");
    step("R10 load both", 1'b0, '0, 1'b0, 2'b00, 1'b1, 2'b11);
    idle("R7 has-room pending");
    step("R9 set wins clear", 1'b0, '0, 1'b0, 2'b01, 1'b0, 2'b00);
    pop("R7 drain");
    step("R9 clear data", 1'b0, '0, 1'b0, 2'b01, 1'b0, 2'b00);
    step("R9 zero no effect", 1'b0, '0, 1'b0, 2'b00, 1'b0, 2'b00);
    for (int i = 0; i < DEPTH; i++) push("R7 fill", 32'h2000_0000 + 32'(i));
    step("R9 clear room at full", 1'b0, '0, 1'b0, 2'b10, 1'b0, 2'b00);
    idle("R9 room stays clear");
    pop("R7 room returns");
    idle("R7 room pending again");
    step("R10 mask off keeps pending", 1'b0, '0, 1'b0, 2'b00, 1'b1, 2'b00);
    idle("R8 masked no set");
    step("R9 clear masked", 1'b0, '0, 1'b0, 2'b11, 1'b0, 2'b00);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule